// File: doc/BRIEF.md
# Power-Up Configuration Loader

This block fetches the adapter's station address and its setup words from an external byte-wide EEPROM without any help from software. Once reset is released, it steps a byte address up from zero and drives a read strobe. For each address it waits a fixed number of cycles and then takes the data byte. Every pair of bytes is packed into one 16-bit word of an internal register file, which always holds eight words.

The host-side target logic looks at `hostRetry`. While that flag is high, every access from the host must be answered with a retry. The flag drops on the same clock edge that writes the last word, and at that edge `loadDone` rises. A board-level test strap, sampled while reset is active, skips the fetch entirely. In that case the register file stays zero and the host is let in at once.

Top module: `cfg_eeprom_loader`

## Requirements
- R1: While `rst` is high, `loadDone` is 0 and `hostRetry` is 1. On the first cycle after reset release, every bit of `cfgWords` is 0.
- R2: During the fetch, `romRdEn` is 1. `romAddr` takes the values 0, 1, ..., 2*WORDS-1 in ascending order and never skips a value.
- R3: Each byte address is held for exactly HOLD_CYCLES clock cycles. `romData` is captured at the last rising edge of that window, so after n edges past reset release the address is n / HOLD_CYCLES.
- R4: Word i of the register file sits at `cfgWords[16*i +: 16]`. Its bits [7:0] hold the byte read at address 2*i and its bits [15:8] hold the byte read at address 2*i+1.
- R5: `loadDone` rises and `hostRetry` falls on the edge that stores the final word. That edge is exactly 2*WORDS*HOLD_CYCLES rising edges after reset release. Before it, `loadDone` is 0.
- R6: `hostRetry` is always the inverse of `loadDone`.
- R7: If `skipLoad` is 1 while reset is active, `loadDone` is 1 after the first edge following release. `romRdEn` stays 0 and `cfgWords` stays all zero.
- R8: Once `loadDone` is 1, it stays 1 until the next reset. After that point `romRdEn` is 0 and `cfgWords` ignores any change on `romData`.
- R9: A reset asserted in the middle of a fetch clears the register file and starts the fetch over from address 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| skipLoad | input | 1 | Test strap that bypasses the fetch; sampled during reset |
| romData | input | 8 | Byte returned by the EEPROM |
| romAddr | output | $clog2(2*WORDS) | Byte address presented to the EEPROM |
| romRdEn | output | 1 | EEPROM read strobe |
| cfgWords | output | 16*WORDS | Register file; word i at [16*i +: 16] |
| loadDone | output | 1 | Fetch complete or bypassed |
| hostRetry | output | 1 | Host accesses must be retried |

## Verification
A hold counter that slips shows up at once on `romAddr`: the address steps one cycle early or late against the n / HOLD_CYCLES schedule. A wrong byte-lane or word-index decode stays hidden until `loadDone` rises, and then shows as a swapped or misplaced word in `cfgWords`. A finish condition that fires on the wrong byte moves the `loadDone` edge away from 2*WORDS*HOLD_CYCLES, which a check of that exact cycle catches. Bypass and mid-fetch reset are covered by directed runs, and the word contents are varied with random EEPROM images.

// File: rtl/cfg_ldr_pkg.sv
package cfg_ldr_pkg;
  typedef struct packed {
    logic sample;   // capture romData this edge
    logic hiByte;   // captured byte is the upper half of a word
    logic finish;   // this capture completes the final word
    logic idle;     // sequencer is parked in its done state
  } ldrStrobe_t;
endpackage

// File: rtl/cfg_ldr_ctrl.sv
module cfg_ldr_ctrl
  import cfg_ldr_pkg::*;
#(
  parameter int WORDS       = 8,
  parameter int HOLD_CYCLES = 4,
  localparam int BYTES = 2 * WORDS,
  localparam int AW    = $clog2(BYTES),
  localparam int IW    = (WORDS > 1) ? $clog2(WORDS) : 1,
  localparam int HW    = (HOLD_CYCLES > 1) ? $clog2(HOLD_CYCLES) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          skipLoad,
  output logic [AW-1:0] romAddr,
  output logic          romRdEn,
  output logic [IW-1:0] wordIdx,
  output ldrStrobe_t    strobe
);
  typedef enum logic {ST_LOAD, ST_DONE} ldrState_t;

  ldrState_t     state;
  logic [AW-1:0] byteCnt;
  logic [HW-1:0] holdCnt;
  logic          lastHold;
  logic          lastByte;

  assign lastHold = (state == ST_LOAD) && (holdCnt == HW'(HOLD_CYCLES - 1));
  assign lastByte = (byteCnt == AW'(BYTES - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= skipLoad ? ST_DONE : ST_LOAD;
      byteCnt <= '0;
      holdCnt <= '0;
    end else if (state == ST_LOAD) begin
      if (lastHold) begin
        holdCnt <= '0;
        if (lastByte) state <= ST_DONE;
        else          byteCnt <= byteCnt + AW'(1);
      end else begin
        holdCnt <= holdCnt + HW'(1);
      end
    end
  end

  always_comb begin
    strobe.sample = lastHold;
    strobe.hiByte = byteCnt[0];
    strobe.finish = lastHold && lastByte;
    strobe.idle   = (state == ST_DONE);
  end

  assign romAddr = byteCnt;
  assign romRdEn = (state == ST_LOAD);
  assign wordIdx = IW'(byteCnt >> 1);
endmodule

// File: rtl/cfg_ldr_data.sv
module cfg_ldr_data
  import cfg_ldr_pkg::*;
#(
  parameter int WORDS = 8,
  localparam int IW = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  ldrStrobe_t          strobe,
  input  logic [IW-1:0]       wordIdx,
  input  logic [7:0]          romData,
  output logic [16*WORDS-1:0] cfgWords,
  output logic                loadDone
);
  logic [7:0] loByte;

  always_ff @(posedge clk) begin
    if (rst)                          loByte <= '0;
    else if (strobe.sample && !strobe.hiByte) loByte <= romData;
  end

  for (genvar i = 0; i < WORDS; i++) begin : g_word
    logic [15:0] wordReg;
    always_ff @(posedge clk) begin
      if (rst)
        wordReg <= '0;
      else if (strobe.sample && strobe.hiByte && wordIdx == IW'(i))
        wordReg <= {romData, loByte};
    end
    assign cfgWords[16*i +: 16] = wordReg;
  end

  always_ff @(posedge clk) begin
    if (rst)                              loadDone <= 1'b0;
    else if (strobe.finish || strobe.idle) loadDone <= 1'b1;
  end
endmodule

// File: rtl/cfg_eeprom_loader.sv
module cfg_eeprom_loader
  import cfg_ldr_pkg::*;
#(
  parameter int WORDS       = 8,
  parameter int HOLD_CYCLES = 4,
  localparam int AW = $clog2(2 * WORDS),
  localparam int IW = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                skipLoad,
  input  logic [7:0]          romData,
  output logic [AW-1:0]       romAddr,
  output logic                romRdEn,
  output logic [16*WORDS-1:0] cfgWords,
  output logic                loadDone,
  output logic                hostRetry
);
  ldrStrobe_t    strobe;
  logic [IW-1:0] wordIdx;

  cfg_ldr_ctrl #(.WORDS(WORDS), .HOLD_CYCLES(HOLD_CYCLES)) u_ctrl (
    .clk(clk), .rst(rst), .skipLoad(skipLoad),
    .romAddr(romAddr), .romRdEn(romRdEn), .wordIdx(wordIdx), .strobe(strobe)
  );

  cfg_ldr_data #(.WORDS(WORDS)) u_data (
    .clk(clk), .rst(rst), .strobe(strobe), .wordIdx(wordIdx),
    .romData(romData), .cfgWords(cfgWords), .loadDone(loadDone)
  );

  assign hostRetry = ~loadDone;
endmodule

// File: rtl/cfg_ldr_checker.sv
module cfg_ldr_checker #(
  parameter int WORDS       = 8,
  parameter int HOLD_CYCLES = 4,
  localparam int AW = $clog2(2 * WORDS)
) (
  input logic                clk,
  input logic                rst,
  input logic [AW-1:0]       romAddr,
  input logic                romRdEn,
  input logic [16*WORDS-1:0] cfgWords,
  input logic                loadDone
);
  logic [AW-1:0] lastAddr;
  int unsigned   dwell;

  always_ff @(posedge clk) begin
    if (rst) begin
      lastAddr <= '0;
      dwell    <= 0;
    end else if (romRdEn) begin
      if (romAddr == lastAddr) dwell <= dwell + 1;
      else begin
        dwell    <= 1;
        lastAddr <= romAddr;
      end
    end
  end

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    (romRdEn && romAddr != lastAddr) |-> (romAddr == lastAddr + AW'(1))); // R2
  AST_HOLD_WINDOW: assert property (@(posedge clk) disable iff (rst)
    (romRdEn && romAddr != lastAddr) |-> (dwell == HOLD_CYCLES)); // R3
  AST_NO_READ_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
    loadDone |-> !romRdEn); // R8
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
    loadDone |=> loadDone); // R8
  AST_WORDS_FROZEN: assert property (@(posedge clk) disable iff (rst)
    loadDone |=> $stable(cfgWords)); // R8
endmodule

bind cfg_eeprom_loader cfg_ldr_checker #(.WORDS(WORDS), .HOLD_CYCLES(HOLD_CYCLES)) u_chk (
  .clk(clk), .rst(rst), .romAddr(romAddr), .romRdEn(romRdEn),
  .cfgWords(cfgWords), .loadDone(loadDone)
);

// File: tb/cfg_eeprom_loader_tb.sv
module cfg_eeprom_loader_tb;
  localparam int WORDS = 8;
  localparam int HOLD  = 4;
  localparam int BYTES = 2 * WORDS;
  localparam int AW    = $clog2(BYTES);
  localparam int TOTAL = BYTES * HOLD;

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic                skipLoad = 1'b0;
  logic [7:0]          romData;
  logic [AW-1:0]       romAddr;
  logic                romRdEn;
  logic [16*WORDS-1:0] cfgWords;
  logic                loadDone;
  logic                hostRetry;
  logic [7:0]          mem [BYTES];
  int                  nChecks = 0;
  int                  nFail = 0;

  always #2.5 clk = ~clk;

  assign romData = romRdEn ? mem[romAddr] : 8'hA5;

  cfg_eeprom_loader #(.WORDS(WORDS), .HOLD_CYCLES(HOLD)) u_dut (
    .clk(clk), .rst(rst), .skipLoad(skipLoad), .romData(romData),
    .romAddr(romAddr), .romRdEn(romRdEn), .cfgWords(cfgWords),
    .loadDone(loadDone), .hostRetry(hostRetry)
  );

  function automatic logic [15:0] expWord(input int i);
    return {mem[2*i+1], mem[2*i]};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic applyReset(input bit skip);
    @(negedge clk);
    rst = 1'b1; skipLoad = skip;
    repeat (3) @(negedge clk);
    chk(loadDone == 1'b0, "R1 loadDone in reset", loadDone, 0);
    chk(hostRetry == 1'b1, "R1 hostRetry in reset", hostRetry, 1);
    rst = 1'b0;
    #0.1;
    chk(cfgWords == '0, "R1 words cleared", cfgWords, 0);
  endtask

  task automatic checkWords(input string req);
    for (int i = 0; i < WORDS; i++)
      chk(cfgWords[16*i +: 16] == expWord(i), req, cfgWords[16*i +: 16], expWord(i));
  endtask

  // Called right after reset release; walks n edges of the fetch.
  task automatic walk(input int edges);
    for (int n = 0; n < edges; n++) begin
      chk(romRdEn == 1'b1, "R2 strobe active", romRdEn, 1);
      chk(romAddr == AW'(n / HOLD), "R3 address schedule", romAddr, n / HOLD);
      chk(loadDone == 1'b0, "R5 not done early", loadDone, 0);
      chk(hostRetry == ~loadDone, "R6 retry inverse", hostRetry, ~loadDone);
      @(posedge clk); @(negedge clk);
    end
  endtask

  task automatic fullLoad(input string tag);
    applyReset(1'b0);
    walk(TOTAL);
    chk(loadDone == 1'b1, "R5 done on last word edge", loadDone, 1);
    chk(hostRetry == 1'b0, "R5 retry released", hostRetry, 0);
    chk(romRdEn == 1'b0, "R8 strobe off after done", romRdEn, 0);
    checkWords({"R4 word packing ", tag});
  endtask

  initial begin
    #100000;
    nFail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    for (int b = 0; b < BYTES; b++) mem[b] = 8'(b * 17 + 3);
    fullLoad("ramp");

    // R8: contents frozen against later EEPROM changes
    for (int b = 0; b < BYTES; b++) mem[b] = ~mem[b];
    repeat (10) @(negedge clk);
    for (int b = 0; b < BYTES; b++) mem[b] = ~mem[b];
    chk(loadDone == 1'b1, "R8 done sticky", loadDone, 1);
    checkWords("R8 words frozen");

    for (int b = 0; b < BYTES; b++) mem[b] = 8'hFF;
    fullLoad("ones");
    for (int b = 0; b < BYTES; b++) mem[b] = (b % 2 == 0) ? 8'h00 : 8'hFF;
    fullLoad("lanes");

    for (int r = 0; r < 5; r++) begin
      for (int b = 0; b < BYTES; b++) mem[b] = 8'($urandom);
      fullLoad("random");
    end

    // R9: reset in the middle of a fetch
    for (int b = 0; b < BYTES; b++) mem[b] = 8'($urandom);
    applyReset(1'b0);
    walk(23);
    for (int b = 0; b < BYTES; b++) mem[b] = 8'($urandom);
    applyReset(1'b0);
    chk(romAddr == '0, "R9 restart at address 0", romAddr, 0);
    walk(TOTAL);
    chk(loadDone == 1'b1, "R9 done after restart", loadDone, 1);
    checkWords("R9 words after restart");

    // R7: bypass strap
    applyReset(1'b1);
    @(posedge clk); @(negedge clk);
    chk(loadDone == 1'b1, "R7 bypass done immediately", loadDone, 1);
    chk(hostRetry == 1'b0, "R7 bypass retry released", hostRetry, 0);
    for (int n = 0; n < 20; n++) begin
      chk(romRdEn == 1'b0, "R7 no reads in bypass", romRdEn, 0);
      @(negedge clk);
    end
    chk(cfgWords == '0, "R7 words stay zero", cfgWords, 0);
    skipLoad = 1'b0;

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule